// File: doc/BRIEF.md
# SPI Slave Engine for a 32K x 8 Serial Memory

This block is the serial front end of a byte-wide random-access memory. A host drives chip select, serial clock, serial input and a hold line. The block brings those pins into the system clock domain, decodes the one-byte opcode that opens each chip-select window, assembles the two-byte address and streams data bytes. Read bytes come out of a synchronous RAM port and are shifted out most significant bit first on an output with a separate drive enable, so that a pad can leave it floating. An address counter steps after every byte and wraps at the top of the 15-bit space. There is no write delay, so a byte goes to the RAM as soon as its eighth bit has been sampled.

Write permission is decided outside the block. The engine presents the address it is about to write on `chk_addr`, and a protection unit answers on `chk_ok`. Status register contents, write-enable latching and power states also live outside. The engine only fetches the status byte for output, hands over a received status byte, and pulses a strobe carrying the opcode of each single-byte command. The system clock must run at least four times faster than the serial clock, because every pin passes through a two-stage synchronizer before its edges are detected.

Top module: `spi_mem_slave`

## Requirements
- R1: Opcode 03h selects a read and 02h a write. Each is followed by two address bytes, high byte first and every byte MSB first. Only bits 14:0 of the 16-bit address are used, and bit 15 is ignored.
- R2: A read streams bytes from consecutive addresses for as long as chip select stays low. Each bit appears on `spi_so` after a falling serial clock edge, and the bench samples it on the next rising edge. The address wraps from 7FFFh to 0000h.
- R3: A write issues one `ram_we` pulse for each complete data byte, at consecutive addresses that wrap from 7FFFh to 0000h.
- R4: A data byte cut short by chip select rising is never written to the RAM.
- R5: A byte whose address `chk_ok` reports as not writable is dropped without an error. The address still advances past it.
- R6: `spi_so_en` is low except while read data (opcode 03h or 05h) is being shifted out, and it is low whenever hold is low or chip select is high.
- R7: While `spi_hold_n` is low, serial clock and chip select edges are ignored and the transfer state is frozen. When hold returns high, the transfer resumes at the same bit.
- R8: Mode 0 (serial clock idle low) and mode 3 (idle high) both work. The idle level is set when chip select falls, and both modes give the same results.
- R9: Opcode 05h returns `sr_rdata`, MSB first, and repeats it for every further byte clocked in the same window.
- R10: Opcode 01h followed by one data byte gives a one-cycle `sr_we` pulse with that byte on `sr_wdata`.
- R11: Opcodes 06h, 04h, B9h and ABh each give a one-cycle `ctl_strobe` with the opcode on `ctl_code` when chip select rises.
- R12: An unknown opcode is ignored until chip select rises. Only the first opcode of a window is decoded; later bytes cause no RAM access and no second command.
- R13: After reset, `spi_so_en`, `ram_re`, `ram_we`, `sr_we` and `ctl_strobe` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_si | input | 1 | Serial data in |
| spi_hold_n | input | 1 | Hold, active low |
| spi_so | output | 1 | Serial data out |
| spi_so_en | output | 1 | Output drive enable for `spi_so` |
| ram_addr | output | 15 | RAM address |
| ram_re | output | 1 | RAM read request; data is expected on `ram_rdata` in the following cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| chk_addr | output | 15 | Address offered to the protection unit |
| chk_ok | input | 1 | Protection unit reports that `chk_addr` is writable |
| sr_rdata | input | 8 | Status byte to return for opcode 05h |
| sr_we | output | 1 | Received status byte is valid |
| sr_wdata | output | 8 | Received status byte |
| ctl_strobe | output | 1 | Single-byte command completed |
| ctl_code | output | 8 | Opcode of that command |

## Verification
Writes and reads are run in both clock modes, so a fault in the mode handling shows up as data that does not round-trip. Address bit 15 is set in one transfer and the start is placed at 7FFEh in another, which separates correct masking and wrap from simple counting. A half byte before chip select rises, a protected boundary inside a burst, and a hold inserted mid-byte with serial clock toggling each give a known miscompare if the engine commits too early, skips the counter step or counts the clock edges seen during hold. Unknown and trailing opcodes, status traffic and the single-byte command strobes are checked against the RAM request count and the strobe queue.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_OP,
    ST_ADDR,
    ST_RDATA,
    ST_WDATA,
    ST_SREG_RD,
    ST_SREG_WR,
    ST_DONE,
    ST_SKIP
  } xfer_state_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk) begin
    if (rst) stg_q <= {STAGES{RST_VAL}};
    else     stg_q <= {stg_q[STAGES-2:0], d};
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spi_front.sv
module spi_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_sck,
  input  logic pin_cs_n,
  input  logic pin_si,
  input  logic pin_hold_n,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic run,
  output logic si_s
);

  localparam int NPIN = 4;

  logic [NPIN-1:0] raw_w;
  logic [NPIN-1:0] syn_w;
  logic            sck_prev_q;

  assign raw_w = {pin_sck, pin_cs_n, pin_si, pin_hold_n};

  spi_in_sync #(
    .W      (NPIN),
    .STAGES (STAGES),
    .RST_VAL(4'b0101)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_w),
    .q  (syn_w)
  );

  // The previous level follows the pin even during hold, so no edge
  // appears when hold is released.
  always_ff @(posedge clk) begin
    if (rst) sck_prev_q <= 1'b0;
    else     sck_prev_q <= syn_w[3];
  end

  assign run       = syn_w[0];
  assign si_s      = syn_w[1];
  assign cs_active = ~syn_w[2];
  assign sck_rise  = run & syn_w[3] & ~sck_prev_q;
  assign sck_fall  = run & ~syn_w[3] & sck_prev_q;

endmodule

// File: rtl/spi_mem_core.sv
module spi_mem_core
  import spi_mem_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck_rise,
  input  logic                 cs_active,
  input  logic                 run,
  input  logic                 si,
  input  logic                 chk_ok,
  input  logic [DATA_W-1:0]    sr_rdata,
  output logic                 ram_re,
  output logic                 ram_we,
  output logic [ADDR_W-1:0]    ram_addr,
  output logic [DATA_W-1:0]    ram_wdata,
  output logic [ADDR_W-1:0]    chk_addr,
  output logic                 sr_we,
  output logic [DATA_W-1:0]    sr_wdata,
  output logic                 ctl_strobe,
  output logic [DATA_W-1:0]    ctl_code,
  output logic                 out_phase,
  output logic [$clog2(DATA_W)-1:0] bit_idx,
  output logic                 tx_ld,
  output logic [DATA_W-1:0]    tx_byte
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  xfer_state_t         state_q;
  logic [CNT_W-1:0]    bit_q;
  logic [DATA_W-2:0]   sh_q;
  logic [HI_W-1:0]     hi_q;
  logic                second_q;
  logic                is_rd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   op_q;
  logic                ram_re_q, ram_we_q, sr_we_q, strobe_q, tx_ld_q;
  logic [ADDR_W-1:0]   ram_addr_q;
  logic [DATA_W-1:0]   ram_wdata_q, sr_wdata_q, code_q, tx_byte_q;

  logic [DATA_W-1:0]   byte_w;
  logic [ADDR_W-1:0]   full_addr_w;
  logic                byte_done_w;

  assign byte_w      = {sh_q, si};
  assign full_addr_w = {hi_q, byte_w};
  assign byte_done_w = sck_rise && (bit_q == LAST_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      bit_q       <= '0;
      sh_q        <= '0;
      hi_q        <= '0;
      second_q    <= 1'b0;
      is_rd_q     <= 1'b0;
      addr_q      <= '0;
      op_q        <= '0;
      ram_re_q    <= 1'b0;
      ram_we_q    <= 1'b0;
      ram_addr_q  <= '0;
      ram_wdata_q <= '0;
      sr_we_q     <= 1'b0;
      sr_wdata_q  <= '0;
      strobe_q    <= 1'b0;
      code_q      <= '0;
      tx_ld_q     <= 1'b0;
      tx_byte_q   <= '0;
    end else begin
      ram_re_q <= 1'b0;
      ram_we_q <= 1'b0;
      sr_we_q  <= 1'b0;
      strobe_q <= 1'b0;
      tx_ld_q  <= 1'b0;
      if (!cs_active) begin
        if (run) begin
          // a completed single-byte command takes effect on deselect
          if (state_q == ST_DONE) begin
            strobe_q <= 1'b1;
            code_q   <= op_q;
          end
          state_q <= ST_IDLE;
          bit_q   <= '0;
        end
      end else if (run) begin
        if (state_q == ST_IDLE) begin
          state_q <= ST_OP;
        end else if (sck_rise) begin
          sh_q  <= byte_w[DATA_W-2:0];
          bit_q <= bit_q + 1'b1;
          if (byte_done_w) begin
            unique case (state_q)
              ST_OP: begin
                op_q <= byte_w;
                case (byte_w)
                  OP_READ, OP_WRITE: begin
                    state_q  <= ST_ADDR;
                    second_q <= 1'b0;
                    is_rd_q  <= (byte_w == OP_READ);
                  end
                  OP_RDSR: begin
                    state_q   <= ST_SREG_RD;
                    tx_ld_q   <= 1'b1;
                    tx_byte_q <= sr_rdata;
                  end
                  OP_WRSR: state_q <= ST_SREG_WR;
                  OP_WREN, OP_WRDI, OP_SLEEP, OP_WAKE: state_q <= ST_DONE;
                  default: state_q <= ST_SKIP;
                endcase
              end
              ST_ADDR: begin
                if (!second_q) begin
                  hi_q     <= byte_w[HI_W-1:0];
                  second_q <= 1'b1;
                end else if (is_rd_q) begin
                  ram_re_q   <= 1'b1;
                  ram_addr_q <= full_addr_w;
                  addr_q     <= full_addr_w + 1'b1;
                  state_q    <= ST_RDATA;
                end else begin
                  addr_q  <= full_addr_w;
                  state_q <= ST_WDATA;
                end
              end
              ST_RDATA: begin
                // prefetch the next byte while the last one finishes
                ram_re_q   <= 1'b1;
                ram_addr_q <= addr_q;
                addr_q     <= addr_q + 1'b1;
              end
              ST_WDATA: begin
                if (chk_ok) begin
                  ram_we_q    <= 1'b1;
                  ram_addr_q  <= addr_q;
                  ram_wdata_q <= byte_w;
                end
                addr_q <= addr_q + 1'b1;
              end
              ST_SREG_RD: begin
                tx_ld_q   <= 1'b1;
                tx_byte_q <= sr_rdata;
              end
              ST_SREG_WR: begin
                sr_we_q    <= 1'b1;
                sr_wdata_q <= byte_w;
                state_q    <= ST_SKIP;
              end
              default: ;
            endcase
          end
        end
      end
    end
  end

  assign ram_re     = ram_re_q;
  assign ram_we     = ram_we_q;
  assign ram_addr   = ram_addr_q;
  assign ram_wdata  = ram_wdata_q;
  assign chk_addr   = addr_q;
  assign sr_we      = sr_we_q;
  assign sr_wdata   = sr_wdata_q;
  assign ctl_strobe = strobe_q;
  assign ctl_code   = code_q;
  assign out_phase  = (state_q == ST_RDATA) || (state_q == ST_SREG_RD);
  assign bit_idx    = bit_q;
  assign tx_ld      = tx_ld_q;
  assign tx_byte    = tx_byte_q;

  assert_hold_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (!run && cs_active) |=> ($stable(state_q) && $stable(bit_q) && $stable(addr_q)));

  assert_write_permit_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> $past(chk_ok));

  assert_no_rd_wr_mix_R3: assert property (@(posedge clk) disable iff (rst)
    !(ram_we && ram_re));

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
    (run && cs_active && byte_done_w && state_q == ST_RDATA)
      |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

  assert_strobe_on_deselect_R11: assert property (@(posedge clk) disable iff (rst)
    ctl_strobe |-> $past(!cs_active));

endmodule

// File: rtl/spi_tx_unit.sv
module spi_tx_unit #(
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sck_fall,
  input  logic                      run,
  input  logic                      cs_active,
  input  logic                      out_phase,
  input  logic [$clog2(DATA_W)-1:0] bit_idx,
  input  logic                      ram_re,
  input  logic [DATA_W-1:0]         ram_rdata,
  input  logic                      ld,
  input  logic [DATA_W-1:0]         ld_byte,
  output logic                      so,
  output logic                      so_en
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] TOP_IDX = CNT_W'(DATA_W - 1);

  logic              pend_q;
  logic [DATA_W-1:0] buf_q;
  logic              act_q, so_q, oe_q;
  logic [DATA_W-1:0] src_w;
  logic              fire_w;

  // RAM data is usable in the cycle it arrives, ahead of the buffer
  assign src_w  = pend_q ? ram_rdata : buf_q;
  assign fire_w = run && cs_active && sck_fall && out_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      buf_q  <= '0;
      act_q  <= 1'b0;
      so_q   <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      pend_q <= ram_re;
      if (pend_q)  buf_q <= ram_rdata;
      else if (ld) buf_q <= ld_byte;
      if (!cs_active)  act_q <= 1'b0;
      else if (fire_w) act_q <= 1'b1;
      if (fire_w) so_q <= src_w[TOP_IDX - bit_idx];
      oe_q <= cs_active && run && (act_q || fire_w);
    end
  end

  assign so    = so_q;
  assign so_en = oe_q;

  assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    so_en |-> $past(run && cs_active));

  assert_so_steady_R2: assert property (@(posedge clk) disable iff (rst)
    (so_en && $past(so_en) && !$past(sck_fall)) |-> $stable(so_q));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int ADDR_W      = 15,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_en,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_re,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_ok,
  input  logic [DATA_W-1:0] sr_rdata,
  output logic              sr_we,
  output logic [DATA_W-1:0] sr_wdata,
  output logic              ctl_strobe,
  output logic [DATA_W-1:0] ctl_code
);

  localparam int CNT_W = $clog2(DATA_W);

  logic             sck_rise, sck_fall, cs_active, run, si_s;
  logic             out_phase, tx_ld;
  logic [CNT_W-1:0] bit_idx;
  logic [DATA_W-1:0] tx_byte;

  spi_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst       (rst),
    .pin_sck   (spi_sck),
    .pin_cs_n  (spi_cs_n),
    .pin_si    (spi_si),
    .pin_hold_n(spi_hold_n),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .cs_active (cs_active),
    .run       (run),
    .si_s      (si_s)
  );

  spi_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .sck_rise  (sck_rise),
    .cs_active (cs_active),
    .run       (run),
    .si        (si_s),
    .chk_ok    (chk_ok),
    .sr_rdata  (sr_rdata),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .ram_addr  (ram_addr),
    .ram_wdata (ram_wdata),
    .chk_addr  (chk_addr),
    .sr_we     (sr_we),
    .sr_wdata  (sr_wdata),
    .ctl_strobe(ctl_strobe),
    .ctl_code  (ctl_code),
    .out_phase (out_phase),
    .bit_idx   (bit_idx),
    .tx_ld     (tx_ld),
    .tx_byte   (tx_byte)
  );

  spi_tx_unit #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .sck_fall (sck_fall),
    .run      (run),
    .cs_active(cs_active),
    .out_phase(out_phase),
    .bit_idx  (bit_idx),
    .ram_re   (ram_re),
    .ram_rdata(ram_rdata),
    .ld       (tx_ld),
    .ld_byte  (tx_byte),
    .so       (spi_so),
    .so_en    (spi_so_en)
  );

endmodule

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck_b = 1'b0, cs_b = 1'b1, si_b = 1'b0, hold_b = 1'b1;
  logic        spi_so, spi_so_en;
  logic [14:0] ram_addr, chk_addr;
  logic        ram_re, ram_we, chk_ok, sr_we, ctl_strobe;
  logic [7:0]  ram_wdata, ram_rdata = 8'h00, sr_rdata = 8'h00, sr_wdata, ctl_code;

  int n_chk = 0, n_fail = 0;
  int prot_lim = 32768;
  int re_cnt = 0;
  int cs_hi_cnt = 0, hold_lo_cnt = 0, oe_viol = 0;
  bit mode3 = 1'b0, oe_seen = 1'b0, done = 1'b0;
  logic [7:0] mem [int];
  int         exp_waddr [$];
  logic [7:0] exp_wdat [$];
  logic [7:0] got_ops [$];
  logic [7:0] got_sr [$];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;

  assign chk_ok = (int'(chk_addr) < prot_lim);

  spi_mem_slave dut_i (
    .clk(clk), .rst(rst),
    .spi_sck(sck_b), .spi_cs_n(cs_b), .spi_si(si_b), .spi_hold_n(hold_b),
    .spi_so(spi_so), .spi_so_en(spi_so_en),
    .ram_addr(ram_addr), .ram_re(ram_re), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .chk_addr(chk_addr), .chk_ok(chk_ok),
    .sr_rdata(sr_rdata), .sr_we(sr_we), .sr_wdata(sr_wdata),
    .ctl_strobe(ctl_strobe), .ctl_code(ctl_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural synchronous RAM
  always @(posedge clk) begin
    if (ram_re) ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 8'h00;
    if (ram_we) mem[int'(ram_addr)] = ram_wdata;
  end

  // per-clock monitor against the reference expectations
  always @(negedge clk) begin
    if (!rst) begin
      cs_hi_cnt   = cs_b ? cs_hi_cnt + 1 : 0;
      hold_lo_cnt = !hold_b ? hold_lo_cnt + 1 : 0;
      if (spi_so_en && (cs_hi_cnt > 4 || hold_lo_cnt > 4)) oe_viol++;
      if (ram_re) re_cnt++;
      if (ram_we) begin
        if (exp_waddr.size() == 0) chk("R4 R5 unexpected write", {17'h0, ram_addr}, 32'hFFFF);
        else begin
          chk("R3 write addr", {17'h0, ram_addr}, exp_waddr.pop_front());
          chk("R3 write data", ram_wdata, exp_wdat.pop_front());
        end
      end
      if (ctl_strobe) got_ops.push_back(ctl_code);
      if (sr_we) got_sr.push_back(sr_wdata);
    end
  end

  task automatic hw();
    repeat (6) @(negedge clk);
  endtask

  task automatic cs_begin(input bit m3);
    mode3 = m3; sck_b = m3; oe_seen = 1'b0;
    hw(); cs_b = 1'b0; hw();
  endtask

  task automatic cs_end();
    if (!mode3) begin sck_b = 1'b0; hw(); end
    cs_b = 1'b1; hw(); hw();
  endtask

  task automatic spi_bit(input logic b, output logic r);
    sck_b = 1'b0; si_b = b; hw();
    sck_b = 1'b1; r = spi_so;
    if (spi_so_en) oe_seen = 1'b1;
    hw();
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic do_write(input bit m3, input logic [15:0] a, input int n, input logic [31:0] dat);
    logic [7:0] rx;
    int cur;
    cur = int'(a[14:0]);
    cs_begin(m3);
    xfer(8'h02, rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = dat[31-8*k -: 8];
      if (cur < prot_lim) begin exp_waddr.push_back(cur); exp_wdat.push_back(d); end
      xfer(d, rx);
      cur = (cur + 1) % 32768;
    end
    cs_end();
  endtask

  task automatic do_read(input bit m3, input logic [15:0] a, input int n);
    logic [7:0] rx;
    cs_begin(m3);
    xfer(8'h03, rx); xfer(a[15:8], rx); xfer(a[7:0], rx);
    chk("R6 no drive during header", {31'h0, oe_seen}, 0);
    for (int k = 0; k < n; k++) xfer(8'h00, rbuf[k]);
    chk("R6 drive during read data", {31'h0, oe_seen}, 1);
    cs_end();
  endtask

  initial begin
    logic [7:0] rx;
    logic [7:0] hb;
    int nops, nre;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13 reset state
    chk("R13 so_en", {31'h0, spi_so_en}, 0);
    chk("R13 ram_we/ram_re", {30'h0, ram_we, ram_re}, 0);
    chk("R13 sr_we/ctl_strobe", {30'h0, sr_we, ctl_strobe}, 0);

    // R1 R3 R8: write in mode 0 with address bit 15 set
    do_write(1'b0, 16'h8010, 3, 32'hA1B2C300);
    // R1 R2 R8: read back in mode 3
    do_read(1'b1, 16'h0010, 3);
    chk("R2 R8 mode3 byte0", rbuf[0], 8'hA1);
    chk("R2 R8 mode3 byte1", rbuf[1], 8'hB2);
    chk("R2 R8 mode3 byte2", rbuf[2], 8'hC3);
    do_read(1'b0, 16'h8011, 1);
    chk("R1 bit15 ignored on read", rbuf[0], 8'hB2);

    // R3 R2 wrap at the top address
    do_write(1'b1, 16'h7FFE, 3, 32'h11223300);
    do_read(1'b0, 16'h7FFF, 2);
    chk("R2 wrap byte at 7FFF", rbuf[0], 8'h22);
    chk("R2 wrap byte at 0000", rbuf[1], 8'h33);

    // R4 partial byte
    cs_begin(1'b0);
    xfer(8'h02, rx); xfer(8'h01, rx); xfer(8'h00, rx);
    exp_waddr.push_back(32'h100); exp_wdat.push_back(8'h55);
    xfer(8'h55, rx);
    for (int i = 0; i < 4; i++) begin logic r; spi_bit(1'b1, r); end
    cs_end();
    do_read(1'b0, 16'h0100, 2);
    chk("R4 full byte kept", rbuf[0], 8'h55);
    chk("R4 partial byte dropped", rbuf[1], 8'h00);

    // R5 protected address
    prot_lim = 32'h200;
    do_write(1'b0, 16'h01FF, 2, 32'h66770000);
    prot_lim = 32768;
    do_read(1'b0, 16'h01FF, 2);
    chk("R5 writable byte", rbuf[0], 8'h66);
    chk("R5 protected byte dropped", rbuf[1], 8'h00);

    // R9 status read, repeated
    sr_rdata = 8'h5A;
    cs_begin(1'b0);
    xfer(8'h05, rx);
    xfer(8'h00, rx); chk("R9 status byte", rx, 8'h5A);
    xfer(8'h00, rx); chk("R9 status repeat", rx, 8'h5A);
    cs_end();

    // R10 status write
    nops = got_sr.size();
    cs_begin(1'b1);
    xfer(8'h01, rx); xfer(8'h3C, rx);
    cs_end();
    chk("R10 sr_we count", got_sr.size(), nops + 1);
    if (got_sr.size() > 0) chk("R10 sr_wdata", got_sr[$], 8'h3C);

    // R11 single-byte commands
    nops = got_ops.size();
    cs_begin(1'b0); xfer(8'h06, rx); cs_end();
    cs_begin(1'b1); xfer(8'hB9, rx); cs_end();
    chk("R11 strobe count", got_ops.size(), nops + 2);
    if (got_ops.size() >= 2) begin
      chk("R11 code 06", got_ops[$-1], 8'h06);
      chk("R11 code B9", got_ops[$], 8'hB9);
    end

    // R12 unknown opcode, then trailing read opcode after a command
    nops = got_ops.size(); nre = re_cnt;
    cs_begin(1'b0);
    xfer(8'h77, rx); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h10, rx); xfer(8'h00, rx);
    chk("R12 unknown opcode drives nothing", {31'h0, oe_seen}, 0);
    cs_end();
    cs_begin(1'b0);
    xfer(8'h04, rx); xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h10, rx); xfer(8'h00, rx);
    cs_end();
    chk("R12 no RAM reads", re_cnt, nre);
    chk("R12 one command only", got_ops.size(), nops + 1);
    if (got_ops.size() > nops) chk("R12 command kept", got_ops[$], 8'h04);

    // R7 hold mid-byte with clock toggling
    cs_begin(1'b0);
    xfer(8'h03, rx); xfer(8'h00, rx); xfer(8'h10, rx);
    for (int i = 7; i >= 5; i--) begin logic r; spi_bit(1'b0, r); hb[i] = r; end
    hold_b = 1'b0; hw();
    sck_b = 1'b0; hw();
    chk("R6 R7 released during hold", {31'h0, spi_so_en}, 0);
    sck_b = 1'b1; hw(); sck_b = 1'b0; hw(); sck_b = 1'b1; hw();
    hold_b = 1'b1; hw();
    for (int i = 4; i >= 0; i--) begin logic r; spi_bit(1'b0, r); hb[i] = r; end
    chk("R7 byte resumed after hold", hb, 8'hA1);
    xfer(8'h00, rx);
    chk("R7 next byte after hold", rx, 8'hB2);
    cs_end();

    chk("R6 idle or hold drive monitor", oe_viol, 0);
    chk("R3 R4 R5 all expected writes seen", exp_waddr.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule